// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is the configuration port of a clock generator. It watches a two-wire serial bus (SCL, SDA) with a fast local clock. Each line passes through a synchronizer and a short glitch filter before start and stop conditions are decoded. A read/write register file of `NREG` bytes is kept, and every byte is exposed as a parallel output for the clock logic next to it. The slave pulls SDA low only for acknowledge bits and for data it sends back. It never stretches SCL.

Only block transfers exist. A write opens with the device address in write direction. Two framing bytes follow; they are acknowledged and discarded. The data bytes after them land in register 0, 1, 2 and onward, and the host may stop after any whole byte. A read opens with the device address in read direction. The slave then sends the value of the count register, followed by registers in ascending order from 0, until the host answers with NACK.

Two register pairs are protected. A pair's live registers change only when both of its bytes arrive in the same transfer. Four strap pins are captured while reset is held and are shown in the low nibble of register 7. That nibble cannot be written.

Top module: `cfg_i2c_slave`

## Requirements
- R1: Address byte D2h (7-bit address 69h, bit 0 = 0, write) and D3h (bit 0 = 1, read) are acknowledged; any other address byte gets NACK (SDA left high on the ninth clock) and the slave ignores the bus until the next start.
- R2: In a write, the two bytes after the address are acknowledged and change no register; data byte k after them (k = 0, 1, ...) is acknowledged and written to register k.
- R3: A stop after any complete data byte ends the write; registers past the last byte written keep their values.
- R4: In a read, the first byte sent is the value of register 8, then register 0, 1, ... (MSB first); a position whose register index is at or above register 8's value, or at or above NREG, sends FFh; after the host's NACK the slave releases SDA.
- R5: Register 8 resets to 08h; a write of 00h to it is dropped and the old value stays.
- R6: Registers 11/12 and 13/14 are pairs: a pair's outputs change only at the stop (or repeated start) of a write that carried both of its bytes; otherwise neither changes.
- R7: After reset, registers 1, 2 and 3 read FFh, register 8 reads 08h, and every other register reads 00h (register 7 low nibble excepted, see R8).
- R8: Bits [3:0] of register 7 show the strap inputs sampled while reset was asserted; later strap changes and writes to those bits have no effect; bits [7:4] are writable.
- R9: The slave changes SDA only while the filtered SCL is low, and never drives SDA while idle or while waiting for the host's acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, at least 16x the bit rate |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| strap_i | input | 4 | Frequency-select strap levels |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 136 | Register contents, register i in bits [8i+7:8i] |

## Verification
A wrong byte or bit counter shows up within one byte on the bus: an acknowledge lands in the wrong slot, or the data lands one register off. Either is seen in the parallel outputs right after the stop, or on the next read-back. A wrong shadow flag or a lost commit leaves a pair half-updated or stale at the stop. This is checked on the outputs a few cycles later. A faulty read index shows in the first bytes after the count, and a faulty count limit in the FFh fill at the end of a long read-back.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int NREG_DEF  = 17;
    localparam int CNT_IDX   = 8;
    localparam int STRAP_IDX = 7;
    localparam int PAIR_N    = 2;
    localparam logic [6:0] DEV_ADDR = 7'h69;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RACK,
        S_TX,
        S_TACK
    } bus_st_t;

    // first register of protected pair p; the pair is (base, base+1)
    function automatic int pair_base(int p);
        return 11 + 2 * p;
    endfunction

    function automatic logic [7:0] reg_reset(int i);
        if (i >= 1 && i <= 3) return 8'hFF;
        if (i == CNT_IDX)     return 8'h08;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfgi2c_line_filter.sv
module cfgi2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          val;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.val) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.val = flt_q.sync[1];
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '{sync: 2'b11, val: 1'b1, cnt: '0};
        else        flt_q <= flt_d;
    end

    assign line_o = flt_q.val;

endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile
    import cfgi2c_pkg::*;
#(
    parameter int NREG    = NREG_DEF,
    parameter int STRAP_W = 4,
    localparam int IW     = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   strap_i,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 commit,
    input  logic [IW-1:0]        rd_idx,
    output logic [7:0]           rd_data,
    output logic [7:0]           cnt_o,
    output logic [NREG*8-1:0]    regs_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0]          regs;
        logic [PAIR_N-1:0][1:0][7:0]   shd;
        logic [PAIR_N-1:0][1:0]        have;
    } rf_t;

    function automatic rf_t rf_init();
        rf_t r;
        r = '0;
        for (int i = 0; i < NREG; i++) r.regs[i] = reg_reset(i);
        return r;
    endfunction

    rf_t rf_d, rf_q;
    logic [STRAP_W-1:0]   strap_q;
    logic [NREG-1:0][7:0] view;

    always_comb begin
        logic hit;
        rf_d = rf_q;
        hit  = 1'b0;
        if (wr_en) begin
            for (int p = 0; p < PAIR_N; p++) begin
                for (int m = 0; m < 2; m++) begin
                    if (int'(wr_idx) == pair_base(p) + m) begin
                        rf_d.shd[p][m]  = wr_data;
                        rf_d.have[p][m] = 1'b1;
                        hit             = 1'b1;
                    end
                end
            end
            if (!hit && !(int'(wr_idx) == CNT_IDX && wr_data == 8'h00))
                rf_d.regs[wr_idx] = wr_data;
        end
        if (commit) begin
            for (int p = 0; p < PAIR_N; p++) begin
                if (&rf_q.have[p]) begin
                    rf_d.regs[pair_base(p)]     = rf_q.shd[p][0];
                    rf_d.regs[pair_base(p) + 1] = rf_q.shd[p][1];
                end
                rf_d.have[p] = 2'b00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= rf_init();
        else        rf_q <= rf_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_q <= strap_i;
    end

    for (genvar gi = 0; gi < NREG; gi++) begin : g_view
        if (gi == STRAP_IDX) begin : g_strap
            assign view[gi] = {rf_q.regs[gi][7:STRAP_W], strap_q};
        end else begin : g_plain
            assign view[gi] = rf_q.regs[gi];
        end
    end

    assign regs_o  = view;
    assign rd_data = view[rd_idx];
    assign cnt_o   = rf_q.regs[CNT_IDX];

    // R5: the read length register never holds zero
    a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.regs[CNT_IDX] != 8'h00);

    // R6: a protected register only moves in a commit cycle
    for (genvar gp = 0; gp < PAIR_N; gp++) begin : g_pair_chk
        for (genvar gm = 0; gm < 2; gm++) begin : g_mem
            a_r6_pair_commit: assert property (@(posedge clk) disable iff (!rst_n)
                (rf_q.regs[pair_base(gp) + gm] != $past(rf_q.regs[pair_base(gp) + gm]))
                |-> $past(commit));
        end
    end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter int NREG     = NREG_DEF,
    parameter int STRAP_W  = 4,
    parameter int FILT_LEN = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [STRAP_W-1:0]   strap_i,
    output logic                 sda_oe,
    output logic [NREG*8-1:0]    regs_o
);
    localparam int IW = $clog2(NREG);
    localparam int PW = $clog2(NREG + 4) + 1;
    localparam logic [PW-1:0] PMAX = '1;

    typedef struct packed {
        bus_st_t       st;
        logic [3:0]    bits;
        logic [7:0]    sh;
        logic [PW-1:0] nbyte;
        logic [PW-1:0] rpos;
        logic          rd;
        logic          nack;
        logic          oe;
        logic          scl_p;
        logic          sda_p;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [1:0] raw, filt;
    assign raw = {scl_i, sda_i};

    for (genvar gl = 0; gl < 2; gl++) begin : g_line
        cfgi2c_line_filter #(.FILT_LEN(FILT_LEN)) i_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[gl]),
            .line_o (filt[gl])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt[1];
    assign sda_f = filt[0];

    logic ev_rise, ev_fall, ev_start, ev_stop;
    assign ev_rise  = scl_f & ~c_q.scl_p;
    assign ev_fall  = ~scl_f & c_q.scl_p;
    assign ev_start = scl_f & c_q.scl_p & c_q.sda_p & ~sda_f;
    assign ev_stop  = scl_f & c_q.scl_p & ~c_q.sda_p & sda_f;

    logic          wr_en, commit;
    logic [PW-1:0] widx_full, ridx_full;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0]    rd_data, cnt_val, tx_byte;

    assign widx_full = c_q.nbyte - PW'(3);
    assign wr_idx    = widx_full[IW-1:0];
    assign ridx_full = c_q.rpos - PW'(1);
    assign rd_idx    = ridx_full[IW-1:0];

    always_comb begin
        if (c_q.rpos == '0)
            tx_byte = cnt_val;
        else if (ridx_full >= PW'(NREG) || 8'(ridx_full) >= cnt_val)
            tx_byte = 8'hFF;
        else
            tx_byte = rd_data;
    end

    always_comb begin
        c_d       = c_q;
        c_d.scl_p = scl_f;
        c_d.sda_p = sda_f;
        wr_en     = 1'b0;
        commit    = 1'b0;
        if (ev_start) begin
            c_d.st    = S_RX;
            c_d.bits  = '0;
            c_d.nbyte = '0;
            c_d.rpos  = '0;
            c_d.rd    = 1'b0;
            c_d.oe    = 1'b0;
            commit    = 1'b1;
        end else if (ev_stop) begin
            c_d.st = S_IDLE;
            c_d.oe = 1'b0;
            commit = 1'b1;
        end else begin
            case (c_q.st)
                S_RX: begin
                    if (ev_rise && c_q.bits < 4'd8) begin
                        c_d.sh   = {c_q.sh[6:0], sda_f};
                        c_d.bits = c_q.bits + 4'd1;
                    end else if (ev_fall && c_q.bits == 4'd8) begin
                        if (c_q.nbyte == '0) begin
                            if (c_q.sh[7:1] == DEV_ADDR) begin
                                c_d.rd = c_q.sh[0];
                                c_d.oe = 1'b1;
                                c_d.st = S_RACK;
                            end else begin
                                c_d.st = S_IDLE;
                            end
                        end else begin
                            c_d.oe = 1'b1;
                            c_d.st = S_RACK;
                            wr_en  = (c_q.nbyte >= PW'(3)) && (widx_full < PW'(NREG));
                        end
                    end
                end
                S_RACK: begin
                    if (ev_fall) begin
                        c_d.bits = '0;
                        if (c_q.nbyte != PMAX) c_d.nbyte = c_q.nbyte + 1'b1;
                        if (c_q.rd) begin
                            c_d.sh   = tx_byte;
                            c_d.oe   = ~tx_byte[7];
                            c_d.rpos = c_q.rpos + 1'b1;
                            c_d.st   = S_TX;
                        end else begin
                            c_d.oe = 1'b0;
                            c_d.st = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (ev_fall) begin
                        if (c_q.bits == 4'd7) begin
                            c_d.oe = 1'b0;
                            c_d.st = S_TACK;
                        end else begin
                            c_d.sh   = {c_q.sh[6:0], 1'b0};
                            c_d.bits = c_q.bits + 4'd1;
                            c_d.oe   = ~c_q.sh[6];
                        end
                    end
                end
                S_TACK: begin
                    if (ev_rise) begin
                        c_d.nack = sda_f;
                    end else if (ev_fall) begin
                        if (c_q.nack) begin
                            c_d.st = S_IDLE;
                        end else begin
                            c_d.sh   = tx_byte;
                            c_d.oe   = ~tx_byte[7];
                            c_d.bits = '0;
                            if (c_q.rpos != PMAX) c_d.rpos = c_q.rpos + 1'b1;
                            c_d.st   = S_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: S_IDLE, bits: '0, sh: '0, nbyte: '0, rpos: '0,
                             rd: 1'b0, nack: 1'b0, oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        else        c_q <= c_d;
    end

    assign sda_oe = c_q.oe;

    cfgi2c_regfile #(.NREG(NREG), .STRAP_W(STRAP_W)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (c_q.sh),
        .commit  (commit),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cnt_o   (cnt_val),
        .regs_o  (regs_o)
    );

    // R1: an address acknowledge follows only a matching address byte
    a_r1_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(c_q.st) == S_RX && c_q.st == S_RACK && $past(c_q.nbyte) == '0)
        |-> ($past(c_q.sh[7:1]) == DEV_ADDR));

    // R9: SDA drive changes only while filtered SCL is low
    a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.oe != $past(c_q.oe)) |-> !scl_f);

    // R9: no drive while idle
    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_IDLE) |-> !c_q.oe);

    // R4: SDA is free while the host answers a sent byte
    a_r4_tack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_TACK) |-> !c_q.oe);

endmodule

// File: tb/test_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_cfg_i2c_slave;
    import cfgi2c_pkg::*;

    localparam int NR = NREG_DEF;
    localparam int H  = 20;
    localparam int Q  = 8;
    localparam logic [3:0] STRAP_RST = 4'hA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic [3:0] strap = STRAP_RST;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic sda_line;

    assign sda_line = ~(host_low | sda_oe);

    always #2.5 clk = ~clk;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe  (sda_oe),
        .regs_o  (regs)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] expv [NR];
    logic [7:0] wbuf [NR];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [31:0] got, input logic [31:0] ex);
        total++;
        if (got !== ex) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", r, got, ex);
        end
    endtask

    task automatic cmp_all(input string r);
        for (int i = 0; i < NR; i++) chk(r, {24'd0, regs[i*8 +: 8]}, {24'd0, expv[i]});
    endtask

    task automatic bus_start();
        host_low = 1'b0; scl = 1'b1; tick(H);
        host_low = 1'b1; tick(H);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        host_low = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_low = ~b[i]; tick(H);
            scl = 1'b1; tick(H);
            scl = 1'b0; tick(Q);
        end
        host_low = 1'b0; tick(H);
        scl = 1'b1; tick(H / 2);
        ack = sda_line; tick(H / 2);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_low = 1'b0; tick(H);
            scl = 1'b1; tick(H / 2);
            b[i] = sda_line; tick(H / 2);
            scl = 1'b0; tick(Q);
        end
        host_low = ~nack; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(Q);
        host_low = 1'b0;
    endtask

    // writes wbuf[0..n-1], then applies the expected-value model
    task automatic write_txn(input int n);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk("R1 write address ack", {31'd0, a}, 32'd0);
        send_byte(8'h55, a); chk("R2 command byte ack", {31'd0, a}, 32'd0);
        send_byte(8'h99, a); chk("R2 count byte ack", {31'd0, a}, 32'd0);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk("R2 data byte ack", {31'd0, a}, 32'd0);
        end
        bus_stop();
        for (int i = 0; i < n; i++) begin
            if (i >= 11 && i <= 14) continue;
            if (i == CNT_IDX && wbuf[i] == 8'h00) continue;
            if (i == STRAP_IDX) expv[i] = {wbuf[i][7:4], STRAP_RST};
            else                expv[i] = wbuf[i];
        end
        if (n >= 13) begin expv[11] = wbuf[11]; expv[12] = wbuf[12]; end
        if (n >= 15) begin expv[13] = wbuf[13]; expv[14] = wbuf[14]; end
        tick(10);
    endtask

    task automatic read_txn(input int nb);
        logic a;
        logic [7:0] b, cnt, e;
        cnt = expv[CNT_IDX];
        bus_start();
        send_byte(8'hD3, a); chk("R1 read address ack", {31'd0, a}, 32'd0);
        recv_byte(1'b0, b);  chk("R4 count byte", {24'd0, b}, {24'd0, cnt});
        for (int k = 1; k <= nb; k++) begin
            recv_byte(k == nb, b);
            e = (k - 1 < int'(cnt) && k - 1 < NR) ? expv[k-1] : 8'hFF;
            chk("R4 read data", {24'd0, b}, {24'd0, e});
        end
        tick(H);
        chk("R4 SDA released after NACK", {31'd0, sda_oe}, 32'd0);
        bus_stop();
        tick(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < NR; i++) expv[i] = reg_reset(i);
        expv[STRAP_IDX] = {4'h0, STRAP_RST};
        tick(10);
        rst_n = 1'b1;
        tick(3);
        strap = 4'h3;
        tick(10);
        // R7 / R8: reset values and captured straps
        cmp_all("R7 reset value");
        chk("R8 strap nibble after pin change", {28'd0, regs[STRAP_IDX*8 +: 4]}, {28'd0, STRAP_RST});

        // R1: foreign address gets NACK and the slave stays quiet
        bus_start();
        send_byte(8'hA0, a); chk("R1 foreign address NACK", {31'd0, a}, 32'd1);
        bus_stop();
        cmp_all("R1 no change after foreign address");

        // R2 / R6 / R8: full write, count register set to 5
        for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 37 + 11) & 255);
        wbuf[CNT_IDX] = 8'h05;
        wbuf[STRAP_IDX] = 8'h4D;
        write_txn(NR);
        cmp_all("R2 full write");
        chk("R8 strap bits not writable", {24'd0, regs[STRAP_IDX*8 +: 8]}, {24'd0, 8'h4A});

        // R4: count byte then 5 registers then FFh fill
        read_txn(6);

        // R5: zero written to the count register is dropped
        for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 53 + 200) & 255);
        wbuf[CNT_IDX] = 8'h00;
        write_txn(9);
        cmp_all("R5 zero count write");
        chk("R5 count kept", {24'd0, regs[CNT_IDX*8 +: 8]}, 32'h05);

        // R6: only the first member of pair 11/12 written
        for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 19 + 7) & 255);
        wbuf[CNT_IDX] = 8'h05;
        write_txn(12);
        chk("R6 pair 11 unchanged", {24'd0, regs[11*8 +: 8]}, {24'd0, expv[11]});
        cmp_all("R6 half pair");

        // R3: stop after three data bytes
        for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 29 + 99) & 255);
        write_txn(3);
        cmp_all("R3 short write");

        // R6: pair 11/12 complete, pair 13/14 half written; count set to 20
        for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 71 + 5) & 255);
        wbuf[CNT_IDX] = 8'd20;
        write_txn(14);
        chk("R6 pair 11 loaded", {24'd0, regs[11*8 +: 8]}, {24'd0, wbuf[11]});
        chk("R6 pair 12 loaded", {24'd0, regs[12*8 +: 8]}, {24'd0, wbuf[12]});
        chk("R6 pair 13 unchanged", {24'd0, regs[13*8 +: 8]}, {24'd0, expv[13]});
        cmp_all("R6 pair mix");

        // R4: long read past the end of the register range
        read_txn(NR + 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule